// File: doc/BRIEF.md
# ATM Cell Header Error Checker with Single-Bit Repair

This block sits in the receive path of an ATM cell stream. It takes one byte per clock and passes it through a five-byte sliding window before it reaches the byte output. The five bytes held at any moment are treated as a candidate cell header. Every cycle the block works out the CRC-8 syndrome of those 40 bits in parallel and removes the fixed coset pattern. One clock later it reports whether the window held a good header.

A controller that already knows where cells start raises a one-cycle repair enable in the cycle the window holds a header. If the syndrome is one of the 40 single-bit patterns, the block flips the affected bit in the window and in the byte leaving it. The header then counts as good and is flagged as repaired. Any other nonzero syndrome gives a bad header, and the bytes pass through untouched.

The block also reports a candidate maintenance cell. This is a good header, after any repair, whose three leading bytes are all zero.

Top module: `hec_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the window and `dout` to zero, sets `hdr_bad` to 1, and sets `hdr_fixed` and `oam_cand` to 0.
- R2: A byte presented on `din` at an edge appears on `dout` after the fifth following edge. Bytes leave in arrival order and are unchanged unless a repair applies to them.
- R3: The header is the 40-bit word with the oldest window byte in bits 39:32 and the newest in bits 7:0. Its syndrome is the remainder of that word divided by x^8+x^2+x+1, XORed with 0x55. When the window holds a header with zero syndrome, `hdr_bad` is 0 after the next edge.
- R4: A nonzero syndrome with `corr_en` low gives `hdr_bad` = 1 after the next edge.
- R5: With `corr_en` high, a syndrome equal to x^i mod the generator for some bit i in 0..39 flips header bit i. The corrected byte is the one on `dout` after that edge, or it stays in the window until it leaves. `hdr_fixed` = 1 and `hdr_bad` = 0.
- R6: With `corr_en` low, no bit is changed and `hdr_fixed` is 0 after the edge.
- R7: With `corr_en` high, a nonzero syndrome that matches none of the 40 patterns gives `hdr_bad` = 1 and `hdr_fixed` = 0, and the bytes pass through unchanged.
- R8: `oam_cand` is 1 after the edge exactly when the header, after any repair, is good and its bits 39:16 are all zero.
- R9: `hdr_fixed` is never 1 while `hdr_bad` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 8 | Incoming stream byte, one per clock |
| corr_en | input | 1 | Repair enable, qualifies the header currently in the window |
| dout | output | 8 | Byte leaving the window, after any repair |
| hdr_bad | output | 1 | High when the last examined header was bad |
| hdr_fixed | output | 1 | High when the last header was repaired |
| oam_cand | output | 1 | High when the last header was good with three zero leading bytes |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 5-byte header, a 3-byte zero test, generator low byte 0x07 and coset 0x55. These are the only values for which the requirements give exact expected numbers.

With these values, the bench's reference can place a single flip at every one of the 40 bit positions. Its search also finds a two-bit error whose syndrome matches no single position, which exercises the unmatched repair path. Random streams with a random repair enable on every cycle also hit overlapping windows, where a repair lands on bytes that later windows examine again.

// File: rtl/hec_pkg.sv
// Package: shared types and constant functions for the header checker.
// Assumes the CRC width equals one byte.
package hec_pkg;
    localparam int CRC_W = 8;
    typedef logic [CRC_W-1:0] crc_t;

    // Returns x^n reduced modulo the generator whose low bits are poly.
    function automatic crc_t xpow(input int n, input crc_t poly);
        crc_t r;
        r = crc_t'(1);
        for (int k = 0; k < n; k++) begin
            r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/hec_syndrome.sv
// Module: hec_syndrome
// Parallel syndrome of the whole window. Each set header bit adds its
// own power of x modulo the generator, and the coset is added on top.
// Assumes hdr bit 0 is the lowest-order term.
module hec_syndrome
    import hec_pkg::*;
#(
    parameter int   HDR_W = 40,
    parameter crc_t POLY  = 8'h07,
    parameter crc_t COSET = 8'h55
) (
    input  logic [HDR_W-1:0] hdr,
    output crc_t             syn
);
    crc_t term [HDR_W];

    genvar i;
    generate
        for (i = 0; i < HDR_W; i++) begin : g_term
            localparam crc_t PAT = xpow(i, POLY);
            // Contribution of header bit i.
            assign term[i] = hdr[i] ? PAT : '0;
        end
    endgenerate

    // XOR all contributions together with the coset.
    always_comb begin
        syn = COSET;
        for (int k = 0; k < HDR_W; k++) begin
            syn = syn ^ term[k];
        end
    end
endmodule

// File: rtl/hec_locator.sv
// Module: hec_locator
// Compares the syndrome against all single-bit error patterns. Output
// bit i is high when a flip of header bit i explains the syndrome.
// Assumes the syndrome already has the coset removed.
module hec_locator
    import hec_pkg::*;
#(
    parameter int   HDR_W = 40,
    parameter crc_t POLY  = 8'h07
) (
    input  crc_t             syn,
    output logic [HDR_W-1:0] hit
);
    genvar i;
    generate
        for (i = 0; i < HDR_W; i++) begin : g_cmp
            localparam crc_t PAT = xpow(i, POLY);
            // One comparator per header bit position.
            assign hit[i] = (syn == PAT);
        end
    endgenerate
endmodule

// File: rtl/hec_window.sv
// Module: hec_window
// Byte shift window. The oldest byte leaves on dout, the others move
// one place towards the exit and the new byte enters at the tail.
// The flip mask is applied as bytes move, which repairs them in place.
// Assumes the flip mask follows the flat header layout, oldest byte
// in the top bits.
module hec_window #(
    parameter int BYTE_W    = 8,
    parameter int HDR_BYTES = 5,
    localparam int HDR_W    = BYTE_W * HDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] din,
    input  logic [HDR_W-1:0]  flip,
    output logic [HDR_W-1:0]  hdr,
    output logic [BYTE_W-1:0] dout
);
    logic [BYTE_W-1:0] win [HDR_BYTES];

    genvar j;
    generate
        for (j = 0; j < HDR_BYTES; j++) begin : g_flat
            // Flatten: slot 0 (oldest) goes into the top byte.
            assign hdr[HDR_W-1-j*BYTE_W -: BYTE_W] = win[j];
        end
    endgenerate

    // Shift with in-place repair; synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            for (int k = 0; k < HDR_BYTES; k++) win[k] <= '0;
        end else begin
            dout <= win[0] ^ flip[HDR_W-1 -: BYTE_W];
            for (int k = 0; k < HDR_BYTES-1; k++) begin
                win[k] <= win[k+1] ^ flip[HDR_W-1-(k+1)*BYTE_W -: BYTE_W];
            end
            win[HDR_BYTES-1] <= din;
        end
    end

    // Without a flip, every byte moves one slot unchanged.
    assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(flip) == '0)) |-> (win[0] == $past(win[1])));
endmodule

// File: rtl/hec_checker.sv
// Module: hec_checker (top)
// ATM header checker. It computes the syndrome of the window every
// cycle, repairs a single-bit error when corr_en qualifies the window,
// and registers the good/bad, repaired and maintenance-candidate flags.
// Assumes corr_en is raised only when the window is aligned on a header.
module hec_checker
    import hec_pkg::*;
#(
    parameter int   BYTE_W    = 8,
    parameter int   HDR_BYTES = 5,
    parameter int   OAM_BYTES = 3,
    parameter crc_t POLY      = 8'h07,
    parameter crc_t COSET     = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] din,
    input  logic              corr_en,
    output logic [BYTE_W-1:0] dout,
    output logic              hdr_bad,
    output logic              hdr_fixed,
    output logic              oam_cand
);
    localparam int HDR_W = BYTE_W * HDR_BYTES;
    localparam int OAM_W = BYTE_W * OAM_BYTES;

    logic [HDR_W-1:0] hdr;
    logic [HDR_W-1:0] hit;
    logic [HDR_W-1:0] flip;
    logic [HDR_W-1:0] fixed_hdr;
    crc_t             syn;
    logic             syn_zero;
    logic             do_fix;
    logic             good;

    hec_window #(.BYTE_W(BYTE_W), .HDR_BYTES(HDR_BYTES)) u_win (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din),
        .flip (flip),
        .hdr  (hdr),
        .dout (dout)
    );

    hec_syndrome #(.HDR_W(HDR_W), .POLY(POLY), .COSET(COSET)) u_syn (
        .hdr(hdr),
        .syn(syn)
    );

    hec_locator #(.HDR_W(HDR_W), .POLY(POLY)) u_loc (
        .syn(syn),
        .hit(hit)
    );

    // Decide on a repair and form the corrected header.
    always_comb begin
        syn_zero  = (syn == '0);
        do_fix    = corr_en && !syn_zero && (|hit);
        flip      = do_fix ? hit : '0;
        fixed_hdr = hdr ^ flip;
        good      = syn_zero || do_fix;
    end

    // Register the header verdict one clock after the window is examined.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_bad   <= 1'b1;
            hdr_fixed <= 1'b0;
            oam_cand  <= 1'b0;
        end else begin
            hdr_bad   <= !good;
            hdr_fixed <= do_fix;
            oam_cand  <= good && (fixed_hdr[HDR_W-1 -: OAM_W] == '0);
        end
    end

    // A repaired header is always reported good.
    assert_fixed_means_good_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_fixed |-> !hdr_bad);

    // A maintenance candidate is always a good header.
    assert_oam_means_good_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oam_cand |-> !hdr_bad);

    // Without the enable, the exiting byte leaves untouched.
    assert_no_edit_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(corr_en)) |-> (dout == $past(hdr[HDR_W-1 -: BYTE_W])));

    // At most one bit position can explain any syndrome.
    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: tb/hec_checker_test.sv
// Bench: a behavioural reference (byte queue, long division and a
// brute-force search for the flip) is compared with the block on every clock.
module hec_checker_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] din;
    logic       corr_en;
    logic [7:0] dout;
    logic       hdr_bad, hdr_fixed, oam_cand;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hec_checker uut (
        .clk(clk), .rst_n(rst_n), .din(din), .corr_en(corr_en),
        .dout(dout), .hdr_bad(hdr_bad), .hdr_fixed(hdr_fixed), .oam_cand(oam_cand)
    );

    // Remainder of a 40-bit word by polynomial long division with 0x107.
    function automatic logic [7:0] lrem(input logic [39:0] h);
        logic [8:0] r = '0;
        for (int i = 39; i >= 0; i--) begin
            r = {r[7:0], h[i]};
            if (r[8]) r = r ^ 9'h107;
        end
        return r[7:0];
    endfunction

    // -2: good as is; bit index: repaired by that flip; -1: no single flip explains it.
    function automatic int find_fix(input logic [39:0] h);
        if (lrem(h) == 8'h55) return -2;
        for (int b = 0; b < 40; b++)
            if (lrem(h ^ (40'd1 << b)) == 8'h55) return b;
        return -1;
    endfunction

    // Reference model state.
    logic [7:0] mq[$];
    logic [7:0] e_dout;
    logic       e_bad, e_fix, e_oam;
    bit         m_ready = 0;

    // Reference update on each rising edge.
    always @(posedge clk) begin
        logic [39:0] h;
        int f;
        if (!rst_n) begin
            mq = {8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
            e_dout = 8'h00; e_bad = 1'b1; e_fix = 1'b0; e_oam = 1'b0;
        end else begin
            h = {mq[0], mq[1], mq[2], mq[3], mq[4]};
            f = find_fix(h);
            e_fix = 1'b0;
            if (f >= 0 && corr_en) begin
                h = h ^ (40'd1 << f);
                e_fix = 1'b1;
            end
            e_bad  = !(f == -2 || e_fix);
            e_oam  = !e_bad && (h[39:16] == 24'h0);
            e_dout = h[39:32];
            mq = {h[31:24], h[23:16], h[15:8], h[7:0], din};
        end
        m_ready = 1;
    end

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (m_ready) begin
            n_vec++;
            if (dout !== e_dout) begin
                n_bad++;
                $display("FAIL R2 R5 R7 dout got %h exp %h at %0t", dout, e_dout, $time);
            end
            n_vec++;
            if (hdr_bad !== e_bad) begin
                n_bad++;
                $display("FAIL R3 R4 R7 hdr_bad got %b exp %b at %0t", hdr_bad, e_bad, $time);
            end
            n_vec++;
            if (hdr_fixed !== e_fix) begin
                n_bad++;
                $display("FAIL R5 R6 R9 hdr_fixed got %b exp %b at %0t", hdr_fixed, e_fix, $time);
            end
            n_vec++;
            if (oam_cand !== e_oam) begin
                n_bad++;
                $display("FAIL R8 oam_cand got %b exp %b at %0t", oam_cand, e_oam, $time);
            end
        end
    end

    task automatic put(input logic [7:0] b, input logic en);
        @(negedge clk);
        din = b;
        corr_en = en;
    endtask

    // Directed flag check, independent of the reference model.
    task automatic expect_flags(input logic b, input logic f, input logic o, input string tag);
        n_vec++;
        if (hdr_bad !== b || hdr_fixed !== f || oam_cand !== o) begin
            n_bad++;
            $display("FAIL %s flags got %b%b%b exp %b%b%b", tag,
                     hdr_bad, hdr_fixed, oam_cand, b, f, o);
        end
    endtask

    // Send a header with an error mask; the repair enable comes in the examining cycle.
    task automatic send_hdr(input logic [31:0] body, input logic [39:0] err, input logic en,
                            input logic xb, input logic xf, input logic xo, input string tag);
        logic [39:0] h;
        h = {body, lrem({body, 8'h00}) ^ 8'h55} ^ err;
        for (int k = 4; k >= 0; k--) put(h[k*8 +: 8], 1'b0);
        put(8'hA5, en);
        @(negedge clk);
        expect_flags(xb, xf, xo, tag);
        corr_en = 1'b0;
        for (int k = 0; k < 5; k++) put(8'h3C, 1'b0);
    endtask

    // Finds a two-bit error that no single flip explains (R7).
    function automatic logic [39:0] unmatched_pair();
        for (int a = 0; a < 40; a++)
            for (int b = a + 1; b < 40; b++)
                if (find_fix({32'h0, 8'h55} ^ (40'd1 << a) ^ (40'd1 << b)) == -1)
                    return (40'd1 << a) ^ (40'd1 << b);
        return 40'd3;
    endfunction

    bit done = 0;

    initial begin
        rst_n = 1'b0; din = 8'h00; corr_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values.
        expect_flags(1'b1, 1'b0, 1'b0, "R1");
        n_vec++;
        if (dout !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 dout got %h exp 00", dout);
        end
        rst_n = 1'b1;

        send_hdr(32'h01020304, 40'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        send_hdr(32'h00000007, 40'h0, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        send_hdr(32'h00000009, 40'd1 << 35, 1'b1, 1'b0, 1'b1, 1'b1, "R5");
        send_hdr(32'h00000009, 40'd1 << 35, 1'b0, 1'b1, 1'b0, 1'b0, "R4 R6");
        send_hdr(32'h12345678, 40'd1, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
        send_hdr(32'h0, unmatched_pair(), 1'b1, 1'b1, 1'b0, 1'b0, "R7");

        // Random headers with zero, one or two flipped bits.
        for (int n = 0; n < 200; n++) begin
            logic [39:0] e;
            int nb;
            nb = $urandom_range(0, 2);
            e = '0;
            for (int q = 0; q < nb; q++) e = e ^ (40'd1 << $urandom_range(0, 39));
            put(8'h00, 1'b0);
            for (int k = 4; k >= 0; k--) begin
                logic [39:0] h;
                h = {((n % 4 == 0) ? 24'h0 : 24'($urandom)), 8'($urandom), 8'h00};
                h[7:0] = lrem({h[39:8], 8'h00}) ^ 8'h55;
                h = h ^ e;
                if (k == 4) mq_hold = h;
                put(mq_hold[k*8 +: 8], 1'b0);
            end
            put(8'($urandom), $urandom_range(0, 1) == 1);
        end

        // Free-running random bytes with a random enable on every cycle.
        for (int n = 0; n < 3000; n++) put(8'($urandom), $urandom_range(0, 3) == 0);

        // Reset in the middle of traffic (R1).
        put(8'hFF, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 10; n++) put(8'($urandom), 1'b0);
        done = 1;
    end

    logic [39:0] mq_hold;

    // Watchdog and summary.
    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule